// File: doc/BRIEF.md
# Sticky Interrupt Status Unit with Dual Mask Gating

This block gathers event conditions from a SPI controller's transmit FIFO, receive FIFO and descriptor engine into a 12-bit vector of sticky status flags. A flag, once set, holds until software clears it by writing a 1 to its position. A flag drives the single interrupt output only when its bit is also set in two independent masks: an enable mask and a signal-enable mask. Both must agree, so software can arm an event in one mask while holding the pin quiet through the other.

The FIFO-related flags are generated inside the block from the FIFO fill levels. Empty and full are detected directly. Threshold events come from comparing each level against a programmable 5-bit threshold. Descriptor-done, packet-complete and DMA-error arrive as pulses. A soft-reset pulse raises the two empty flags, because the FIFOs are flushed by it. Access is through a plain register port with a single-cycle write and a combinational read. There is no streaming data path, so no valid/ready handshake is present.

Register map (word index on the address pins): 0 = status (write 1 to clear), 1 = enable mask, 2 = signal-enable mask, 3 = thresholds.

Top module: `irq_status_unit`

## Requirements
- R1: While and after reset, status, enable mask and signal-enable mask read 0 and `irq_o` is 0. The threshold register reads 0x0000001F, which is a transmit threshold of 0 and a receive threshold of 31.
- R2: Status bit positions are as follows. Transmit empty is bit 0, transmit full 1, transmit threshold 2, receive empty 3, receive full 4, receive threshold 5, descriptor done 9, packet complete 10 and DMA error 11. An event sets its bit on the next clock edge, and the bit stays set after the cause is gone.
- R3: Writing status (address 0) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If a bit's event and its clear occur in the same cycle, the bit remains set.
- R5: Masks do not affect status. A bit set while masked stays readable and set.
- R6: `irq_o` is 1 only if some bit is set in status, in the enable mask (address 1) and in the signal-enable mask (address 2) at the same time.
- R7: `irq_o` is registered. It changes one clock after the status or mask change that causes it.
- R8: The threshold register (address 3) holds the transmit threshold in bits 12:8 and the receive threshold in bits 4:0. All other bits read 0.
- R9: The transmit threshold event occurs while the transmit level is at or below the transmit threshold. The receive threshold event occurs while the receive level is at or above the receive threshold.
- R10: The empty event occurs while a level equals 0, and the full event occurs while a level equals FIFO_DEPTH (default 16).
- R11: A `soft_rst_i` pulse sets status bits 0 and 3.
- R12: Status and mask bits 6 to 8 and 12 and above read 0 and cannot be written to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 2 | Write word index |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 2 | Read word index |
| reg_rdata_o | output | 32 | Read data (combinational) |
| tx_level_i | input | 5 | Transmit FIFO fill level |
| rx_level_i | input | 5 | Receive FIFO fill level |
| desc_done_i | input | 1 | Descriptor-done pulse |
| pkt_done_i | input | 1 | Packet-complete pulse |
| dma_err_i | input | 1 | DMA error pulse |
| soft_rst_i | input | 1 | Controller soft-reset pulse |
| irq_o | output | 1 | Interrupt output |

## Verification
A corrupted status flag is visible on the next status read. It is also visible on `irq_o` one clock later when both masks arm that bit, so each mismatch is caught within one or two cycles of its cause. Mask corruption shows up only through the interrupt pin and the mask read-back. For this reason, the bench walks the interrupt through each mask alone and then through both together, and it samples the exact cycle of the pin's change. Threshold and level comparisons are exercised on each side of every boundary: equal, one above and one below. Clears are issued while the cause persists, so that event priority becomes visible on a status read.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int STS_W = 12;
  localparam int THR_W = 5;
  localparam int TX_THR_LSB = 8;
  localparam int RX_THR_LSB = 0;

  localparam int B_TXE = 0;
  localparam int B_TXF = 1;
  localparam int B_TXT = 2;
  localparam int B_RXE = 3;
  localparam int B_RXF = 4;
  localparam int B_RXT = 5;
  localparam int B_BDD = 9;
  localparam int B_PKT = 10;
  localparam int B_ERR = 11;

  localparam logic [STS_W-1:0] IMPL_MASK = 12'hE3F;

  typedef enum logic [1:0] {
    A_STS = 2'd0,
    A_EN  = 2'd1,
    A_SIG = 2'd2,
    A_THR = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/fifo_event_gen.sv
module fifo_event_gen #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5,
  parameter int THR_W = 5,
  parameter bit IS_TX = 1'b1
) (
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             ev_empty_o,
  output logic             ev_full_o,
  output logic             ev_thr_o
);
  localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

  logic [CMP_W-1:0] lvl_x;
  logic [CMP_W-1:0] thr_x;

  assign lvl_x      = CMP_W'(lvl_i);
  assign thr_x      = CMP_W'(thr_i);
  assign ev_empty_o = (lvl_i == '0);
  assign ev_full_o  = (lvl_i == LVL_W'(DEPTH));

  generate
    if (IS_TX) begin : g_tx
      // transmit side wants refill while the level has drained to the mark
      assign ev_thr_o = (lvl_x <= thr_x);
    end else begin : g_rx
      // receive side wants draining once the level has climbed to the mark
      assign ev_thr_o = (lvl_x >= thr_x);
    end
  endgenerate
endmodule

// File: rtl/sticky_status.sv
module sticky_status #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_i) | set_i;  // set dominates clear
  end

  assign sts_o = sts_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_chk
      // R2: a set flag holds unless a clear is applied
      a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[i] && !clr_i[i]) |=> sts_q[i]);
      // R4: an event always leaves the flag set, even with a clear
      a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> sts_q[i]);
      // R3: a clear without an event empties the flag
      a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !sts_q[i]);
    end
  endgenerate
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int W = 12,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic         wr_sig_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] sts_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] sig_o,
  output logic         irq_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] sig_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      sig_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_en_i)  en_q  <= wdata_i & IMPL;
      if (wr_sig_i) sig_q <= wdata_i & IMPL;
      irq_q <= |(sts_i & en_q & sig_q);
    end
  end

  assign en_o  = en_q;
  assign sig_o = sig_q;
  assign irq_o = irq_q;

  // R6: the pin can only be high if status was non-zero the cycle before
  a_r6_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(|sts_i));
  // R6: a mask cleared to zero forces the pin low on the next cycle
  a_r6_en_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq_q);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              desc_done_i,
  input  logic              pkt_done_i,
  input  logic              dma_err_i,
  input  logic              soft_rst_i,
  output logic              irq_o
);
  import isu_pkg::*;

  localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;
  localparam int THR_TOP = TX_THR_LSB + THR_W;

  logic [THR_W-1:0] thr_tx_q, thr_rx_q;
  logic [STS_W-1:0] sts, en_m, sig_m, set_v, clr_v;
  logic tx_e, tx_f, tx_t, rx_e, rx_f, rx_t;
  logic wr_sts, wr_en, wr_sig, wr_thr;
  logic unused_hi;

  assign unused_hi = ^reg_wdata_i[DATA_W-1:THR_TOP];

  assign wr_sts = reg_wr_i && (reg_waddr_i == ADDR_W'(A_STS));
  assign wr_en  = reg_wr_i && (reg_waddr_i == ADDR_W'(A_EN));
  assign wr_sig = reg_wr_i && (reg_waddr_i == ADDR_W'(A_SIG));
  assign wr_thr = reg_wr_i && (reg_waddr_i == ADDR_W'(A_THR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_tx_q <= '0;
      thr_rx_q <= '1;
    end else if (wr_thr) begin
      thr_tx_q <= reg_wdata_i[TX_THR_LSB +: THR_W];
      thr_rx_q <= reg_wdata_i[RX_THR_LSB +: THR_W];
    end
  end

  fifo_event_gen #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .THR_W(THR_W), .IS_TX(1'b1)) i_tx_ev (
    .lvl_i(tx_level_i), .thr_i(thr_tx_q),
    .ev_empty_o(tx_e), .ev_full_o(tx_f), .ev_thr_o(tx_t)
  );

  fifo_event_gen #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .THR_W(THR_W), .IS_TX(1'b0)) i_rx_ev (
    .lvl_i(rx_level_i), .thr_i(thr_rx_q),
    .ev_empty_o(rx_e), .ev_full_o(rx_f), .ev_thr_o(rx_t)
  );

  always_comb begin
    set_v        = '0;
    set_v[B_TXE] = tx_e | soft_rst_i;
    set_v[B_TXF] = tx_f;
    set_v[B_TXT] = tx_t;
    set_v[B_RXE] = rx_e | soft_rst_i;
    set_v[B_RXF] = rx_f;
    set_v[B_RXT] = rx_t;
    set_v[B_BDD] = desc_done_i;
    set_v[B_PKT] = pkt_done_i;
    set_v[B_ERR] = dma_err_i;
    set_v        = set_v & IMPL_MASK;
  end

  assign clr_v = wr_sts ? (reg_wdata_i[STS_W-1:0] & IMPL_MASK) : '0;

  sticky_status #(.W(STS_W)) i_sts (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .sts_o(sts)
  );

  irq_gate #(.W(STS_W), .IMPL(IMPL_MASK)) i_gate (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sig_i(wr_sig),
    .wdata_i(reg_wdata_i[STS_W-1:0]), .sts_i(sts),
    .en_o(en_m), .sig_o(sig_m), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_raddr_i)
      ADDR_W'(A_STS): reg_rdata_o = DATA_W'(sts);
      ADDR_W'(A_EN):  reg_rdata_o = DATA_W'(en_m);
      ADDR_W'(A_SIG): reg_rdata_o = DATA_W'(sig_m);
      default: begin
        reg_rdata_o[TX_THR_LSB +: THR_W] = thr_tx_q;
        reg_rdata_o[RX_THR_LSB +: THR_W] = thr_rx_q;
      end
    endcase
  end

  // R9: a transmit threshold flag only rises after level <= threshold
  a_r9_tx_thr_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[B_TXT]) |-> (CMP_W'($past(tx_level_i)) <= CMP_W'($past(thr_tx_q))));
  // R9: a receive threshold flag only rises after level >= threshold
  a_r9_rx_thr_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[B_RXT]) |-> (CMP_W'($past(rx_level_i)) >= CMP_W'($past(thr_rx_q))));
  // R12: unimplemented positions never hold a one
  a_r12_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts | en_m | sig_m) & ~IMPL_MASK) == '0);
endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  raddr = '0;
  logic [31:0] rdata;
  logic [4:0]  tx_lvl = 5'd8;
  logic [4:0]  rx_lvl = 5'd4;
  logic        ev_done = 0, ev_pkt = 0, ev_err = 0, ev_srst = 0;
  logic        irq;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_waddr_i(waddr),
    .reg_wdata_i(wdata), .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .tx_level_i(tx_lvl), .rx_level_i(rx_lvl), .desc_done_i(ev_done),
    .pkt_done_i(ev_pkt), .dma_err_i(ev_err), .soft_rst_i(ev_srst), .irq_o(irq)
  );

  // monitor: pops each expected item and compares it against the outputs
  initial begin
    forever begin
      wait (q.size() > 0);
      #1;
      begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_irq ? {31'd0, irq} : rdata;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    raddr = a;
    q.push_back('{1'b0, e, tag});
    wait (q.size() == 0);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    q.push_back('{1'b1, {31'd0, e}, tag});
    wait (q.size() == 0);
  endtask

  task automatic wr_ev(input logic do_wr, input logic [1:0] a, input logic [31:0] d,
                       input logic [3:0] ev);
    @(negedge clk);
    reg_wr = do_wr; waddr = a; wdata = d;
    {ev_srst, ev_err, ev_pkt, ev_done} = ev;
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
    {ev_srst, ev_err, ev_pkt, ev_done} = 4'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_ev(1'b1, a, d, 4'b0);
  endtask

  task automatic set_lvl(input logic [4:0] t, input logic [4:0] r);
    @(negedge clk);
    tx_lvl = t; rx_lvl = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state, sampled while reset is held
    chk_reg(2'd0, 32'h0, "R1 status in reset");
    chk_reg(2'd3, 32'h0000001F, "R1 threshold in reset");
    chk_irq(1'b0, "R1 irq in reset");
    @(negedge clk) rst_n = 1'b1;
    chk_reg(2'd0, 32'h0, "R1 status after reset");
    chk_reg(2'd1, 32'h0, "R1 enable after reset");
    chk_reg(2'd2, 32'h0, "R1 signal-enable after reset");

    // R12 reserved mask bits
    wr(2'd1, 32'hFFFF_FFFF);
    chk_reg(2'd1, 32'h00000E3F, "R12 enable reserved bits");
    wr(2'd1, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    chk_reg(2'd2, 32'h00000E3F, "R12 signal-enable reserved bits");
    wr(2'd2, 32'h0);

    // R2 descriptor done at bit 9, sticky
    wr_ev(1'b0, 2'd0, 32'h0, 4'b0001);
    chk_reg(2'd0, 32'h200, "R2 descriptor done bit 9");
    chk_reg(2'd0, 32'h200, "R2 sticky after pulse");

    // R6/R7 two-level gating and latency
    wr(2'd1, 32'h200);
    chk_irq(1'b0, "R6 enable only");
    chk_irq(1'b0, "R6 enable only, later");
    wr(2'd2, 32'h200);
    chk_irq(1'b0, "R7 irq one cycle late");
    chk_irq(1'b1, "R6 both masks armed");
    wr(2'd1, 32'h0);
    chk_irq(1'b1, "R7 irq holds one cycle");
    chk_irq(1'b0, "R6 enable removed");
    chk_reg(2'd0, 32'h200, "R5 status kept while masked");

    // R3 write-one-to-clear
    wr(2'd0, 32'h0);
    chk_reg(2'd0, 32'h200, "R3 zero write keeps");
    wr(2'd0, 32'h200);
    chk_reg(2'd0, 32'h0, "R3 one write clears");

    // R4 event and clear in the same cycle, packet complete bit 10
    wr_ev(1'b1, 2'd0, 32'h400, 4'b0010);
    chk_reg(2'd0, 32'h400, "R4 event beats clear");
    wr(2'd0, 32'h400);
    wr_ev(1'b0, 2'd0, 32'h0, 4'b0100);
    chk_reg(2'd0, 32'h800, "R2 dma error bit 11");
    wr(2'd0, 32'h800);

    // R8 threshold fields
    wr(2'd3, 32'hFFFF_0A07);
    chk_reg(2'd3, 32'h00000A07, "R8 threshold readback");
    chk_reg(2'd0, 32'h004, "R9 tx level 8 <= 10");
    set_lvl(5'd11, 5'd4);
    wr(2'd0, 32'h004);
    chk_reg(2'd0, 32'h0, "R9 tx level 11 above threshold");
    set_lvl(5'd11, 5'd7);
    chk_reg(2'd0, 32'h020, "R9 rx level equals threshold");
    set_lvl(5'd11, 5'd6);
    wr(2'd0, 32'h020);
    chk_reg(2'd0, 32'h0, "R9 rx level 6 below threshold");
    set_lvl(5'd10, 5'd6);
    chk_reg(2'd0, 32'h004, "R9 tx level equals threshold");
    set_lvl(5'd11, 5'd6);
    wr(2'd0, 32'h004);

    // R10 full and empty
    set_lvl(5'd16, 5'd6);
    chk_reg(2'd0, 32'h002, "R10 tx full bit 1");
    set_lvl(5'd11, 5'd6);
    wr(2'd0, 32'h002);
    set_lvl(5'd11, 5'd16);
    chk_reg(2'd0, 32'h030, "R10 rx full bit 4 with rx threshold");
    set_lvl(5'd11, 5'd6);
    wr(2'd0, 32'hFFF);
    chk_reg(2'd0, 32'h0, "R3 clear all");
    set_lvl(5'd0, 5'd6);
    chk_reg(2'd0, 32'h005, "R10 tx empty bit 0");
    set_lvl(5'd11, 5'd0);
    chk_reg(2'd0, 32'h00D, "R10 rx empty bit 3");
    wr(2'd0, 32'hFFF);
    chk_reg(2'd0, 32'h008, "R4 persisting rx empty survives clear");
    set_lvl(5'd11, 5'd6);
    wr(2'd0, 32'hFFF);
    chk_reg(2'd0, 32'h0, "R3 cleared after cause gone");

    // R11 soft reset event
    wr_ev(1'b0, 2'd0, 32'h0, 4'b1000);
    chk_reg(2'd0, 32'h009, "R11 soft reset sets empties");

    // R6 non-overlapping masks, then a matching event
    wr(2'd1, 32'h800);
    wr(2'd2, 32'h800);
    chk_irq(1'b0, "R6 masks miss status");
    chk_irq(1'b0, "R6 masks miss status, later");
    wr_ev(1'b0, 2'd0, 32'h0, 4'b0100);
    chk_reg(2'd0, 32'h809, "R2 dma error joins");
    chk_irq(1'b1, "R7 irq after dma error");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule